// File: doc/BRIEF.md
# Serial Register-Access Slave

This block is the slave side of a four-wire serial link. Through it, a host reads and writes a small bank of 11-bit registers. The serial clock, the select line and the serial data input are not used as clocks. Each one passes through a two-stage synchronizer into a faster system clock, and the block finds the edges of the serial clock in that domain. A frame lasts for one low period of the select line and holds exactly 16 bits. The first bit chooses read or write, the next four bits give the register address and the last eleven bits carry write data.

During every frame the block shifts one register out on the serial output, most significant bit first. For a read, this is the register's current contents. For a write, it is the value the register held before the write. A write takes effect only when the select line returns high after exactly 16 serial clock falls. A frame of any other length is thrown away and sets an error flag. The lowest addresses are read-only status words taken from an input bus. The configuration registers follow them and are visible on an output bus. Addresses above the bank read as zero. The system clock must run at least four times as fast as the serial clock.

Top module: `spi_regbank_slave`

## Requirements
- R1: A frame is the low period of `cs_n`. SDI is captured on each falling edge of `sclk`, most significant bit first. Word bit 15 is the direction (1 = read, 0 = write), bits 14:11 are the register address and bits 10:0 are the write data.
- R2: `sdo` changes only after a rising edge of `sclk` or at the start of a frame. In the 16-bit output word, bits 15:11 are driven 0 and bits 10:0 carry register data, most significant bit first. Bit 15 follows the first rising edge.
- R3: A read frame returns the addressed register's contents in output bits 10:0 and leaves every register unchanged.
- R4: A 16-bit write frame to a configuration address returns that register's previous value in output bits 10:0. The new value appears on `cfg_out` after `cs_n` rises.
- R5: A frame with any number of `sclk` falls other than 16, zero included, changes no register and sets `frame_err`. `frame_err` changes only when a frame ends, and the next 16-bit frame clears it.
- R6: While `cs_n` is high, `sdo_oe` is 0. Activity on `sclk` and `sdi` changes neither the registers nor `frame_err`.
- R7: Addresses 0 to NUM_STAT-1 are status words. Status word a reads back as `status_in[a*11 +: 11]`, and writes to these addresses have no effect.
- R8: Addresses NUM_REGS and above always read as zero, and writes to them are dropped.
- R9: After reset, all configuration registers are zero, `frame_err` is 0 and `sdo_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver (1 = drive) |
| status_in | input | NUM_STAT*DW (22) | Read-only status words, address 0 in the low bits |
| cfg_out | output | (NUM_REGS-NUM_STAT)*DW (110) | Configuration registers, lowest configuration address in the low bits |
| frame_err | output | 1 | Set by a frame of wrong length, cleared by a valid frame |

## Verification
Two situations are hardest to reach from the ports: a frame whose length is off by only one clock, and a frame whose write must return the old register contents. The stimulus runs random frames and gives some of them 0, 1, 15, 17 or 20 clocks, with random extra bits. After each wrong-length frame it checks that the register bus is unchanged and that the error flag is set. Each frame writes or reads a random address and compares the returned word with a bench model of the register bank. Directed frames cover the bank boundaries: status and unused addresses, the first and last configuration address, and clock toggling while the select line is high.

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave #(
  parameter int DW       = 11,
  parameter int AW       = 4,
  parameter int NUM_REGS = 12,
  parameter int NUM_STAT = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             sclk,
  input  logic                             cs_n,
  input  logic                             sdi,
  output logic                             sdo,
  output logic                             sdo_oe,
  input  logic [NUM_STAT*DW-1:0]           status_in,
  output logic [(NUM_REGS-NUM_STAT)*DW-1:0] cfg_out,
  output logic                             frame_err
);
  localparam int FW      = 1 + AW + DW;
  localparam int NUM_CFG = NUM_REGS - NUM_STAT;
  localparam int CW      = $clog2(FW + 2);
  localparam logic [CW-1:0] CNT_FULL = CW'(FW);
  localparam logic [CW-1:0] CNT_HEAD = CW'(AW + 1);
  localparam logic [CW-1:0] CNT_SAT  = CW'(FW + 1);

  logic [2:0]    sclk_q, cs_q;
  logic [1:0]    sdi_q;
  logic          cs_active, sfall, srise, cs_fall, cs_rise;
  logic [CW-1:0] cnt;
  logic [FW-1:0] rx;
  logic [DW-1:0] txsh, rd_val;
  logic          sdo_r;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] wr_data;
  logic          wr_ok;
  logic [DW-1:0] cfg_q [NUM_CFG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 3'b000;
      cs_q   <= 3'b111;
      sdi_q  <= 2'b00;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      cs_q   <= {cs_q[1:0], cs_n};
      sdi_q  <= {sdi_q[0], sdi};
    end
  end

  assign cs_active = ~cs_q[1];
  assign sfall     = cs_active & sclk_q[2] & ~sclk_q[1];
  assign srise     = cs_active & ~sclk_q[2] & sclk_q[1];
  assign cs_fall   = cs_q[2] & ~cs_q[1];
  assign cs_rise   = ~cs_q[2] & cs_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      rx  <= '0;
    end else if (cs_fall) begin
      cnt <= '0;
      rx  <= '0;
    end else if (sfall) begin
      rx <= {rx[FW-2:0], sdi_q[1]};
      if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
    end
  end

  assign rd_addr = rx[AW-1:0];

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_STAT; i++)
      if (rd_addr == AW'(i)) rd_val = status_in[i*DW +: DW];
    for (int i = 0; i < NUM_CFG; i++)
      if (rd_addr == AW'(i + NUM_STAT)) rd_val = cfg_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo_r <= 1'b0;
      txsh  <= '0;
    end else if (cs_fall) begin
      sdo_r <= 1'b0;
    end else if (srise) begin
      if (cnt == CNT_HEAD) begin
        sdo_r <= rd_val[DW-1];
        txsh  <= {rd_val[DW-2:0], 1'b0};
      end else if (cnt > CNT_HEAD && cnt < CNT_FULL) begin
        sdo_r <= txsh[DW-1];
        txsh  <= {txsh[DW-2:0], 1'b0};
      end else begin
        sdo_r <= 1'b0;
      end
    end
  end

  assign sdo    = sdo_r;
  assign sdo_oe = cs_active;

  assign wr_ok   = cs_rise & (cnt == CNT_FULL) & ~rx[FW-1];
  assign wr_addr = rx[FW-2 -: AW];
  assign wr_data = rx[DW-1:0];

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q[g] <= '0;
      else if (wr_ok && wr_addr == AW'(g + NUM_STAT)) cfg_q[g] <= wr_data;
    end
    assign cfg_out[g*DW +: DW] = cfg_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_err <= 1'b0;
    else if (cs_rise) frame_err <= (cnt != CNT_FULL);
  end
endmodule

// File: rtl/spi_regbank_slave_chk.sv
module spi_regbank_slave_chk #(
  parameter int CW = 5,
  parameter int FW = 16,
  parameter int AW = 4,
  parameter int W  = 110
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cnt,
  input logic          sdo,
  input logic          sdo_oe,
  input logic          srise,
  input logic          cs_fall,
  input logic          cs_rise,
  input logic          frame_err,
  input logic [W-1:0]  cfg_out
);
  AST_HEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && cnt < CW'(AW + 1)) |-> !sdo); // R2
  AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!srise && !cs_fall) |=> $stable(sdo)); // R2
  AST_NO_COMMIT_BAD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != CW'(FW)) |=> $stable(cfg_out)); // R5
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> ($past(cs_rise) && $past(cnt) != CW'(FW))); // R5
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(frame_err)); // R5
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(FW + 1)); // R5
endmodule

bind spi_regbank_slave spi_regbank_slave_chk #(
  .CW(CW), .FW(FW), .AW(AW), .W(NUM_CFG*DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .sdo(sdo), .sdo_oe(sdo_oe),
  .srise(srise), .cs_fall(cs_fall), .cs_rise(cs_rise),
  .frame_err(frame_err), .cfg_out(cfg_out)
);

// File: tb/spi_regbank_slave_test.sv
module spi_regbank_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;
  localparam int DW = 11;
  localparam int NUM_REGS = 12;
  localparam int NUM_STAT = 2;
  localparam int NUM_CFG = NUM_REGS - NUM_STAT;

  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, sdi = 0;
  logic sdo, sdo_oe, frame_err;
  logic [NUM_STAT*DW-1:0] status_in;
  logic [NUM_CFG*DW-1:0] cfg_out;
  logic [DW-1:0] stat [NUM_STAT];
  logic [DW-1:0] mcfg [NUM_CFG];
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign status_in = {stat[1], stat[0]};

  spi_regbank_slave uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .status_in(status_in),
    .cfg_out(cfg_out), .frame_err(frame_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_read(input int a);
    if (a < NUM_STAT) return stat[a];
    if (a < NUM_REGS) return mcfg[a-NUM_STAT];
    return '0;
  endfunction

  task automatic check_bank(input string tag);
    logic ok = 1'b1;
    for (int i = 0; i < NUM_CFG; i++)
      if (cfg_out[i*DW +: DW] !== mcfg[i]) ok = 1'b0;
    check(tag, {31'd0, ok}, 32'd1);
  endtask

  task automatic run_frame(input int nbits, input logic [15:0] word,
                           output logic [15:0] got, output logic oe_ok);
    got = '0;
    oe_ok = 1'b1;
    @(negedge clk) cs_n = 0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1;
      sdi = (i < 16) ? word[15-i] : 1'($urandom);
      repeat (HALF) @(negedge clk);
      if (i < 16) got[15-i] = sdo;
      oe_ok &= sdo_oe;
      sclk = 0;
      repeat (HALF) @(negedge clk);
    end
    cs_n = 1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic frame(input int nbits, input bit rd, input int addr, input logic [DW-1:0] data,
                       input string tag);
    logic [15:0] word, got;
    logic [DW-1:0] exp;
    logic oe_ok;
    word = {rd, 4'(addr), data};
    exp = exp_read(addr);
    run_frame(nbits, word, got, oe_ok);
    if (nbits == 16) begin
      check({tag, " R3 R4 data out"}, {21'd0, got[10:0]}, {21'd0, exp});
      check({tag, " R2 head zero"}, {27'd0, got[15:11]}, 32'd0);
      if (!rd && addr >= NUM_STAT && addr < NUM_REGS) mcfg[addr-NUM_STAT] = data;
    end
    if (nbits > 0) check({tag, " R6 oe in frame"}, {31'd0, oe_ok}, 32'd1);
    check({tag, " R5 frame_err"}, {31'd0, frame_err}, {31'd0, nbits != 16});
    check({tag, " R6 oe idle"}, {31'd0, sdo_oe}, 32'd0);
    check_bank({tag, " R1 R7 R8 bank"});
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    stat[0] = 11'h5a3;
    stat[1] = 11'h0c7;
    for (int i = 0; i < NUM_CFG; i++) mcfg[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R9 frame_err", {31'd0, frame_err}, 32'd0);
    check("R9 sdo_oe", {31'd0, sdo_oe}, 32'd0);
    check("R9 cfg zero", cfg_out[31:0], 32'd0);
    check_bank("R9 bank");

    frame(16, 0, 2, 11'h7ff, "R4 first cfg");
    frame(16, 0, 2, 11'h123, "R4 old value");
    frame(16, 1, 2, 11'h000, "R3 read back");
    frame(16, 0, 11, 11'h4d2, "R4 last cfg");
    frame(16, 1, 0, 11'h000, "R7 status0");
    frame(16, 0, 1, 11'h3ff, "R7 status write");
    stat[1] = 11'h6e1;
    frame(16, 1, 1, 11'h000, "R7 status live");
    frame(16, 0, 13, 11'h2aa, "R8 unused write");
    frame(16, 1, 15, 11'h000, "R8 unused read");
    frame(15, 0, 3, 11'h155, "R5 short");
    frame(17, 0, 3, 11'h155, "R5 long");
    frame(16, 1, 3, 11'h000, "R5 recover");
    frame(0, 0, 4, 11'h001, "R5 empty");

    for (int i = 0; i < 24; i++) begin
      @(negedge clk) sclk = ~sclk;
      sdi = 1'($urandom);
      repeat (3) @(negedge clk);
    end
    sclk = 0;
    repeat (2*HALF) @(negedge clk);
    check("R6 err kept", {31'd0, frame_err}, 32'd1);
    check_bank("R6 bank kept");
    frame(16, 1, 4, 11'h000, "R6 after idle toggles");

    for (int n = 0; n < 60; n++) begin
      int pick, nb;
      pick = int'($urandom_range(0, 9));
      case (pick)
        0: nb = 15;
        1: nb = 17;
        2: nb = 1;
        3: nb = 20;
        default: nb = 16;
      endcase
      frame(nb, 1'($urandom), int'($urandom_range(0, 15)), 11'($urandom), "R1 random");
    end
    finish_run();
  end
endmodule